// File: doc/BRIEF.md
# Flash ECC Error Classifier and Logger

This block sits behind the ECC checker of a flash read path. On every checked read it receives a single-bit-error flag, a double-bit-error flag and the read address. It decides whether the event counts as correctable or uncorrectable, and signals it on one of two severity pulse outputs. It also drives a held external error pin, records sticky status flags and captures the failing address.

Double-bit errors are always uncorrectable. A single-bit error in the main program region is always corrected. In the one-time-programmable region, the ECC-word region and the mirrored region, a single-bit error is promoted to uncorrectable when the mode field holds the promotion code. A debug-halt input can block both logging and release, unless a control bit says to ignore it.

After an event is logged, the captured address and status stay frozen. A read of the failing-address register releases them. Software programs the block through a small register port: a control word, a status word and the captured address.

Top module: `flash_ecc_err_log`

## Requirements
- R1: After reset the control word (register select 0) reads 0x0000005A: mode field bits [3:0] = 0xA, enable key bits [7:4] = 0x5, halt-ignore bit [8] = 0. After reset the status word (select 1) and the address word (select 2) read 0, and err_low, err_high and err_pin are low.
- R2: A write to the control word takes effect only when reg_priv is 1; with reg_priv 0 the word is unchanged. Control bits [31:9] always read 0. Selects 1 and 2 cannot be written, and select 3 reads 0.
- R3: A double-bit error at any address is uncorrectable. It gives an err_high pulse and sets status bit 2, whether or not the single-bit flag is also set.
- R4: A single-bit error in the main region gives an err_low pulse and sets status bit 0 for every mode value. The main region is every address outside the three special spans.
- R5: The special spans are 0x20000000–0x20FFFFFF (mirror), 0xF0000000–0xF0FFFFFF (one-time-programmable) and 0xF1000000–0xF1FFFFFF (ECC words). A single-bit error in a special span is uncorrectable when the mode field is 0x5: it gives err_high and sets status bit 1. For every other mode value it gives err_low and sets status bit 0.
- R6: Suppose an error is presented before clock edge k. Its status and address are readable after edge k. Its severity pulse is high for exactly the one cycle after edge k+1. err_low and err_high are never high together.
- R7: err_pin rises together with every err_high pulse and stays high until a releasing read of the address word.
- R8: A logged event sets status bit 3 (frozen). While frozen, later errors still pulse, but the captured address and status bits 0–2 do not change.
- R9: A read of select 2 with reg_rd high is a release: it returns the captured address and clears the status word and err_pin at the next edge. An error presented in the same cycle as a release is logged as a fresh capture.
- R10: With halt-ignore 0 and dbg_halt high, an error sets no status, captures nothing and gives no pulse, and a read of select 2 does not release.
- R11: With halt-ignore 1, dbg_halt has no effect on logging, pulses or release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | ECC check result valid this cycle |
| chk_sbe | input | 1 | Single-bit error detected |
| chk_dbe | input | 1 | Double-bit error detected |
| chk_addr | input | 32 | Address of the checked read |
| dbg_halt | input | 1 | Debug halt indication from the CPU |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 failing address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (release on select 2) |
| reg_priv | input | 1 | Access made in privileged mode |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current select |
| err_low | output | 1 | Correctable-error pulse |
| err_high | output | 1 | Uncorrectable-error pulse |
| err_pin | output | 1 | Held external error indication |

## Verification
The bench sweeps all sixteen mode codes against all four address classes and both error kinds. A design that compared the wrong mode code, or applied promotion in the main region, would show up as a swapped pulse and a wrong status bit. Span edges are probed one word inside and one word outside, so an off-by-one tag compare would misclassify an address. A release coinciding with a new error is checked, because a priority slip there either loses the new capture or leaves the block frozen. The halt-gating and halt-ignore paths are checked for both logging and release, since a design that gated only one of them would log under debug or refuse to release.

// File: rtl/ecc_log_pkg.sv
// Package: shared types and field positions for the flash ECC error logger.
// Assumes a four-bit status word with the frozen flag at the top.
package ecc_log_pkg;

    // One classified ECC event, produced per checked read.
    typedef struct packed {
        logic hit;       // an error of any kind was seen
        logic high;      // uncorrectable severity
        logic corr;      // single-bit, corrected
        logic promoted;  // single-bit, promoted to uncorrectable
        logic dbl;       // double-bit
    } ecc_evt_t;

    localparam int STAT_W      = 4;
    localparam int ST_CORR     = 0;
    localparam int ST_PROMOTED = 1;
    localparam int ST_DBL      = 2;
    localparam int ST_FROZEN   = 3;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;

endpackage

// File: rtl/ecc_ctrl_regs.sv
// Module: control word holding the mode code, enable key and halt-ignore bit.
// Assumes writes are single-cycle strobes; only privileged writes change state.
// Unused upper write-data bits are discarded; they read back as zero.
module ecc_ctrl_regs #(
    parameter int DATA_W = 32,
    parameter int MODE_W = 4,
    parameter int KEY_W  = 4,
    parameter logic [MODE_W-1:0] MODE_RST = 4'hA,
    parameter logic [KEY_W-1:0]  KEY_RST  = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [DATA_W-1:0] wdata,
    output logic [MODE_W-1:0] mode,
    output logic              halt_ign,
    output logic [DATA_W-1:0] ctrl_word
);
    localparam int MODE_LSB = 0;
    localparam int KEY_LSB  = MODE_LSB + MODE_W;
    localparam int HALT_BIT = KEY_LSB + KEY_W;
    localparam int USED_W   = HALT_BIT + 1;

    logic [KEY_W-1:0] key_q;
    logic             unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:USED_W];

    // Field storage: reset values, then privileged writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_RST;
            key_q    <= KEY_RST;
            halt_ign <= 1'b0;
        end else if (wr_en && wr_priv) begin
            mode     <= wdata[MODE_LSB +: MODE_W];
            key_q    <= wdata[KEY_LSB +: KEY_W];
            halt_ign <= wdata[HALT_BIT];
        end
    end

    // Readback image with reserved bits held at zero.
    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[MODE_LSB +: MODE_W] = mode;
        ctrl_word[KEY_LSB +: KEY_W]   = key_q;
        ctrl_word[HALT_BIT]           = halt_ign;
    end
endmodule

// File: rtl/ecc_region_dec.sv
// Module: flags addresses that fall in one of the special spans.
// Assumes every span is 2**SPAN_LOG2 bytes, aligned to its own size.
module ecc_region_dec #(
    parameter int ADDR_W    = 32,
    parameter int SPAN_LOG2 = 24,
    parameter int NUM_SPAN  = 3,
    parameter logic [NUM_SPAN*ADDR_W-1:0] BASES =
        {32'hF100_0000, 32'hF000_0000, 32'h2000_0000}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              special
);
    localparam int TAG_W = ADDR_W - SPAN_LOG2;

    logic [NUM_SPAN-1:0] hit;
    logic                unused_low;

    assign unused_low = ^addr[SPAN_LOG2-1:0];

    // One tag comparator per span.
    for (genvar g = 0; g < NUM_SPAN; g++) begin : g_span
        assign hit[g] = (addr[ADDR_W-1:SPAN_LOG2] ==
                         BASES[g*ADDR_W + SPAN_LOG2 +: TAG_W]);
    end

    assign special = |hit;
endmodule

// File: rtl/ecc_err_classify.sv
// Module: turns raw ECC flags into a severity-tagged event.
// Assumes a double-bit flag dominates a simultaneous single-bit flag.
module ecc_err_classify
    import ecc_log_pkg::*;
#(
    parameter int MODE_W = 4,
    parameter logic [MODE_W-1:0] PROMOTE_CODE = 4'h5
) (
    input  logic              valid,
    input  logic              sbe,
    input  logic              dbe,
    input  logic              special,
    input  logic [MODE_W-1:0] mode,
    output ecc_evt_t          evt
);
    logic single;
    logic promote;

    // Severity decision for this read.
    always_comb begin
        single       = valid && sbe && !dbe;
        promote      = special && (mode == PROMOTE_CODE);
        evt.dbl      = valid && dbe;
        evt.promoted = single && promote;
        evt.corr     = single && !promote;
        evt.high     = evt.dbl || evt.promoted;
        evt.hit      = evt.dbl || single;
    end
endmodule

// File: rtl/ecc_evt_capture.sv
// Module: sticky status, frozen failing address, severity pulses, error pin.
// Assumes log_ok already folds in the halt gating; release_req likewise.
module ecc_evt_capture
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ecc_evt_t          evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              log_ok,
    input  logic              release_req,
    output logic [STAT_W-1:0] status,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              err_low,
    output logic              err_high,
    output logic              err_pin
);
    logic       take;
    logic       capture;
    logic       frozen_q;
    logic [2:0] flags_q;
    logic       acc_hi_q;
    logic       acc_lo_q;

    assign take    = evt.hit && log_ok;
    assign capture = take && (!frozen_q || release_req);

    // Capture and freeze; release clears unless a new event lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen_q <= 1'b0;
            flags_q  <= '0;
            cap_addr <= '0;
        end else if (capture) begin
            frozen_q <= 1'b1;
            flags_q  <= {evt.dbl, evt.promoted, evt.corr};
            cap_addr <= evt_addr;
        end else if (release_req) begin
            frozen_q <= 1'b0;
            flags_q  <= '0;
        end
    end

    // Accepted-event stage, one cycle ahead of the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi_q <= 1'b0;
            acc_lo_q <= 1'b0;
        end else begin
            acc_hi_q <= take && evt.high;
            acc_lo_q <= take && !evt.high;
        end
    end

    // Severity pulses issued the cycle after logging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_high <= 1'b0;
            err_low  <= 1'b0;
        end else begin
            err_high <= acc_hi_q;
            err_low  <= acc_lo_q;
        end
    end

    // Held error pin: set by uncorrectable pulses, cleared by release.
    always_ff @(posedge clk) begin
        if (!rst_n)           err_pin <= 1'b0;
        else if (acc_hi_q)    err_pin <= 1'b1;
        else if (release_req) err_pin <= 1'b0;
    end

    assign status = {frozen_q, flags_q};
endmodule

// File: rtl/flash_ecc_err_log.sv
// Module: top of the flash ECC error classifier and logger.
// Assumes ADDR_W does not exceed DATA_W; register reads are combinational.
module flash_ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MODE_W    = 4,
    parameter int SPAN_LOG2 = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              chk_sbe,
    input  logic              chk_dbe,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              dbg_halt,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_priv,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              err_low,
    output logic              err_high,
    output logic              err_pin
);
    logic [MODE_W-1:0] mode;
    logic              halt_ign;
    logic [DATA_W-1:0] ctrl_word;
    logic              special;
    ecc_evt_t          evt;
    logic              log_ok;
    logic              release_req;
    logic [STAT_W-1:0] status;
    logic [ADDR_W-1:0] cap_addr;

    // Halt gating shared by logging and release.
    assign log_ok      = halt_ign || !dbg_halt;
    assign release_req = reg_rd && (reg_addr == SEL_ADDR) && log_ok;

    ecc_ctrl_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && (reg_addr == SEL_CTRL)), .wr_priv(reg_priv),
        .wdata(reg_wdata), .mode(mode), .halt_ign(halt_ign),
        .ctrl_word(ctrl_word)
    );

    ecc_region_dec #(.ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2)) u_region (
        .addr(chk_addr), .special(special)
    );

    ecc_err_classify #(.MODE_W(MODE_W)) u_class (
        .valid(chk_valid), .sbe(chk_sbe), .dbe(chk_dbe),
        .special(special), .mode(mode), .evt(evt)
    );

    ecc_evt_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .evt(evt), .evt_addr(chk_addr),
        .log_ok(log_ok), .release_req(release_req),
        .status(status), .cap_addr(cap_addr),
        .err_low(err_low), .err_high(err_high), .err_pin(err_pin)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            SEL_CTRL: reg_rdata = ctrl_word;
            SEL_STAT: reg_rdata[STAT_W-1:0] = status;
            SEL_ADDR: reg_rdata[ADDR_W-1:0] = cap_addr;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/flash_ecc_err_log_chk.sv
// Module: property checker bound to the logger top.
// Assumes the default 32-bit widths and the mirror span as lowest special base.
module flash_ecc_err_log_chk #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] LOW_SPECIAL = 32'h2000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_valid,
    input logic              chk_sbe,
    input logic              chk_dbe,
    input logic [ADDR_W-1:0] chk_addr,
    input logic              dbg_halt,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              reg_priv,
    input logic [31:0]       reg_rdata,
    input logic              err_low,
    input logic              err_high,
    input logic              err_pin,
    input logic              halt_ign,
    input logic [3:0]        mode,
    input logic [3:0]        status,
    input logic [ADDR_W-1:0] cap_addr
);
    logic blocked;
    logic rel_read;

    assign blocked  = dbg_halt && !halt_ign;
    assign rel_read = reg_rd && (reg_addr == 2'd2);

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_low && err_high)); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[31:9] == 23'd0)); // R2

    AST_NOPRIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_priv) |=> ($stable(mode) && $stable(halt_ign))); // R2

    AST_HALT_NOLOG: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> ($stable(status) && $stable(cap_addr))); // R10

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !rel_read) |=> $stable(cap_addr)); // R8

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pin && !(rel_read && !blocked)) |=> err_pin); // R7

    AST_HIGH_SETS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        err_high |-> err_pin); // R7

    AST_MAIN_SBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_sbe && !chk_dbe && (chk_addr < LOW_SPECIAL) && !blocked)
        |=> ##1 err_low); // R4
endmodule

bind flash_ecc_err_log flash_ecc_err_log_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_sbe(chk_sbe),
    .chk_dbe(chk_dbe), .chk_addr(chk_addr), .dbg_halt(dbg_halt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_priv(reg_priv),
    .reg_rdata(reg_rdata), .err_low(err_low), .err_high(err_high),
    .err_pin(err_pin), .halt_ign(halt_ign), .mode(mode), .status(status),
    .cap_addr(cap_addr)
);

// File: tb/flash_ecc_err_log_bench.sv
module flash_ecc_err_log_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0, chk_sbe = 1'b0, chk_dbe = 1'b0;
    logic [31:0] chk_addr = '0;
    logic        dbg_halt = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_priv = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_low, err_high, err_pin;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    flash_ecc_err_log u_flash_ecc_err_log (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_sbe(chk_sbe),
        .chk_dbe(chk_dbe), .chk_addr(chk_addr), .dbg_halt(dbg_halt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_priv(reg_priv), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_low(err_low), .err_high(err_high), .err_pin(err_pin)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d, input logic priv);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_priv = priv;
        @(negedge clk);
        reg_wr = 1'b0; reg_priv = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic strobe, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = strobe;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Presents one error; returns status after the logging edge, pulses one
    // cycle later, and the pulse state two cycles before/after that window.
    task automatic inject(input logic [31:0] a, input logic s, input logic d,
                          output logic [31:0] st1, output logic [1:0] p1,
                          output logic hi, output logic lo, output logic pin,
                          output logic [1:0] p3);
        @(negedge clk);
        chk_addr = a; chk_sbe = s; chk_dbe = d; chk_valid = 1'b1; reg_addr = 2'd1;
        @(negedge clk);
        chk_valid = 1'b0; chk_sbe = 1'b0; chk_dbe = 1'b0;
        st1 = reg_rdata; p1 = {err_high, err_low};
        @(negedge clk);
        hi = err_high; lo = err_low; pin = err_pin;
        @(negedge clk);
        p3 = {err_high, err_low};
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, st1, a;
        logic [1:0]  p1, p3;
        logic        hi, lo, pin, s, d, eh;
        logic [31:0] bases [4];
        string       tag;
        bases[0] = 32'h0000_1000; bases[1] = 32'h2000_0000;
        bases[2] = 32'hF000_0000; bases[3] = 32'hF100_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0, 1'b0, v); check(v == 32'h5A, "R1 ctrl", v, 32'h5A);
        rd_reg(2'd1, 1'b0, v); check(v == 0, "R1 status", v, 0);
        rd_reg(2'd2, 1'b0, v); check(v == 0, "R1 addr", v, 0);
        check({err_low, err_high, err_pin} == 3'b0, "R1 outputs",
              {29'd0, err_low, err_high, err_pin}, 0);

        // R2 privilege and reserved bits
        wr_reg(2'd0, 32'h0000_01FF, 1'b0);
        rd_reg(2'd0, 1'b0, v); check(v == 32'h5A, "R2 nonpriv ignored", v, 32'h5A);
        wr_reg(2'd0, 32'hFFFF_FFFF, 1'b1);
        rd_reg(2'd0, 1'b0, v); check(v == 32'h1FF, "R2 reserved zero", v, 32'h1FF);
        wr_reg(2'd1, 32'hFFFF_FFFF, 1'b1);
        rd_reg(2'd1, 1'b0, v); check(v == 0, "R2 status not writable", v, 0);
        rd_reg(2'd3, 1'b0, v); check(v == 0, "R2 select3 zero", v, 0);
        wr_reg(2'd0, 32'h5A, 1'b1);

        // R3 R4 R5 sweep of mode x region x kind
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 4; r++) begin
                for (int t = 0; t < 2; t++) begin
                    wr_reg(2'd0, {23'd0, 1'b0, 4'h5, m[3:0]}, 1'b1);
                    a  = bases[r] + (m << 4) + (t << 2);
                    s  = (t == 0); d = (t == 1);
                    eh = d || (r != 0 && m == 5);
                    tag = d ? "R3" : ((r == 0) ? "R4" : "R5");
                    inject(a, s, d, st1, p1, hi, lo, pin, p3);
                    v = {28'd0, 1'b1, d, s && eh, s && !eh};
                    check(st1 == v, {tag, " status"}, st1, v);
                    check(hi == eh && lo == !eh, {tag, " pulse"},
                          {30'd0, hi, lo}, {30'd0, eh, !eh});
                    check(p1 == 0 && p3 == 0, "R6 single-cycle pulse",
                          {28'd0, p1, p3}, 0);
                    check(pin == eh, "R7 pin", {31'd0, pin}, {31'd0, eh});
                    rd_reg(2'd2, 1'b1, v); check(v == a, "R8 captured addr", v, a);
                    rd_reg(2'd1, 1'b0, v); check(v == 0, "R9 release status", v, 0);
                    check(err_pin == 1'b0, "R9 release pin", {31'd0, err_pin}, 0);
                end
            end
        end

        // R5 span edges in promotion mode
        wr_reg(2'd0, 32'h55, 1'b1);
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: begin a = 32'h1FFF_FFFC; eh = 1'b0; end
                1: begin a = 32'h20FF_FFFC; eh = 1'b1; end
                2: begin a = 32'h2100_0000; eh = 1'b0; end
                3: begin a = 32'hF1FF_FFFC; eh = 1'b1; end
                default: begin a = 32'hF200_0000; eh = 1'b0; end
            endcase
            inject(a, 1'b1, 1'b0, st1, p1, hi, lo, pin, p3);
            check(hi == eh && lo == !eh, "R5 span edge",
                  {30'd0, hi, lo}, {30'd0, eh, !eh});
            rd_reg(2'd2, 1'b1, v);
        end

        // R8 freeze holds first capture, later error still pulses
        wr_reg(2'd0, 32'h5A, 1'b1);
        inject(32'h100, 1'b0, 1'b1, st1, p1, hi, lo, pin, p3);
        inject(32'h200, 1'b1, 1'b0, st1, p1, hi, lo, pin, p3);
        check(lo == 1'b1 && hi == 1'b0, "R8 pulse while frozen",
              {30'd0, hi, lo}, 32'd1);
        rd_reg(2'd1, 1'b0, v); check(v == 32'hC, "R8 status held", v, 32'hC);
        rd_reg(2'd2, 1'b0, v); check(v == 32'h100, "R8 addr held", v, 32'h100);
        rd_reg(2'd2, 1'b1, v);

        // R9 release coinciding with a new error
        inject(32'h300, 1'b1, 1'b0, st1, p1, hi, lo, pin, p3);
        @(negedge clk);
        reg_addr = 2'd2; reg_rd = 1'b1;
        chk_addr = 32'h400; chk_sbe = 1'b1; chk_valid = 1'b1;
        #1 v = reg_rdata;
        check(v == 32'h300, "R9 release returns addr", v, 32'h300);
        @(negedge clk);
        reg_rd = 1'b0; chk_valid = 1'b0; chk_sbe = 1'b0;
        rd_reg(2'd1, 1'b0, v); check(v == 32'h9, "R9 fresh capture status", v, 32'h9);
        rd_reg(2'd2, 1'b1, v); check(v == 32'h400, "R9 fresh capture addr", v, 32'h400);

        // R10 halt blocks logging and release
        dbg_halt = 1'b1;
        inject(32'h500, 1'b0, 1'b1, st1, p1, hi, lo, pin, p3);
        check(st1 == 0, "R10 no status", st1, 0);
        check(hi == 0 && lo == 0, "R10 no pulse", {30'd0, hi, lo}, 0);
        dbg_halt = 1'b0;
        inject(32'h600, 1'b1, 1'b0, st1, p1, hi, lo, pin, p3);
        dbg_halt = 1'b1;
        rd_reg(2'd2, 1'b1, v);
        rd_reg(2'd1, 1'b0, v); check(v == 32'h9, "R10 release blocked", v, 32'h9);
        dbg_halt = 1'b0;
        rd_reg(2'd2, 1'b1, v);
        rd_reg(2'd1, 1'b0, v); check(v == 0, "R10 release after halt", v, 0);

        // R11 halt ignored
        wr_reg(2'd0, 32'h15A, 1'b1);
        dbg_halt = 1'b1;
        inject(32'h700, 1'b0, 1'b1, st1, p1, hi, lo, pin, p3);
        check(st1 == 32'hC, "R11 logs under halt", st1, 32'hC);
        check(hi == 1'b1, "R11 pulse under halt", {31'd0, hi}, 1);
        rd_reg(2'd2, 1'b1, v);
        rd_reg(2'd1, 1'b0, v); check(v == 0, "R11 release under halt", v, 0);
        check(err_pin == 1'b0, "R11 pin released", {31'd0, err_pin}, 0);
        dbg_halt = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule